// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital controller of a 16-bit differential charge-redistribution converter. While idle it keeps the converter in the acquisition phase: the input-grounding switches are closed, the capacitor arrays track the analog inputs, and the analog section is powered down. A falling edge on the active-low convert input starts a conversion. The block powers up the analog section and opens the grounding switches. One cycle later it moves the arrays from the inputs to ground.

The block then runs a binary search on its own clock, which is independent of any serial data clock. The search makes one bit trial per cycle, starting with the most significant bit. Each trial presents a code to the capacitive DAC and reads the comparator decision. That decision keeps or clears the bit under test. When the least significant bit is resolved, the block returns to acquisition and powers down. In the same cycle it publishes the code of this sample in two's complement, so there is no pipeline delay.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset, the outputs are: `busy_o`=0, `pwr_on_o`=0, `sw_open_o`=0, `arr_gnd_o`=0, `dac_code_o`=0, `result_o`=0 and `result_valid_o`=0.
- R2: A high-to-low transition of `conv_n_i`, sampled while idle, sets `busy_o`, `pwr_on_o` and `sw_open_o` at the next clock edge.
- R3: In the first busy cycle, `sw_open_o`=1 and `arr_gnd_o`=0, so the arrays are still on the inputs. From the second busy cycle until the conversion ends, both signals are 1.
- R4: From the third busy cycle, `dac_code_o` steps through W trial codes, one per cycle. Trial k (k = W-1 down to 0) carries the already resolved bits above k, a 1 at bit k and zeros below it. The first trial code is 0x8000.
- R5: A comparator decision `cmp_i`=1 during trial k keeps bit k, and `cmp_i`=0 clears it.
- R6: `busy_o` stays high for exactly W+2 cycles (18 by default). It falls in the same cycle in which `result_valid_o` pulses high for one cycle.
- R7: When a conversion ends, `pwr_on_o`, `sw_open_o` and `arr_gnd_o` all return to 0.
- R8: `result_o` is the resolved binary code with its MSB inverted, so 0x8000 maps to 0x0000, all ones maps to 0x7FFF and zero maps to 0x8000. The value belongs to the conversion that just ended and is held until the next conversion completes.
- R9: A falling edge of `conv_n_i` while `busy_o`=1 has no effect. Holding `conv_n_i` low after a conversion does not start another one.
- R10: `dac_code_o` is 0 whenever `busy_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_n_i | input | 1 | Active-low convert request; its falling edge starts a conversion |
| cmp_i | input | 1 | Comparator decision for the current trial (1 = keep bit) |
| busy_o | output | 1 | High while a conversion is in progress |
| pwr_on_o | output | 1 | Analog section power enable |
| sw_open_o | output | 1 | Input-grounding switches open |
| arr_gnd_o | output | 1 | Capacitor arrays switched from the inputs to ground |
| dac_code_o | output | W | Trial code driving the capacitive DAC |
| result_o | output | W | Two's-complement conversion result |
| result_valid_o | output | 1 | One-cycle pulse when `result_o` updates |

## Verification
A corrupted search register shows at the ports in the same cycle. `dac_code_o` then breaks the expected trial sequence, which the bench predicts from the analog level it models. A bad bit therefore shows up at the first wrong trial, well before the result. A wrong sequencer state shows up as a wrong switch order or power output in the first two busy cycles, or as a busy window other than W+2 cycles. Result mapping errors show up when the valid pulse is sampled. They are checked at the full-scale ends, at midscale and on random levels.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_ACQ,
    ST_OPEN,
    ST_GND,
    ST_TRIAL
  } sar_state_e;
endpackage

// File: rtl/sar_fall_det.sv
// Falling-edge detector on the active-low convert request.
module sar_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b1;
    else     lvl_q <= lvl_i;
  end

  assign fall_o = lvl_q & ~lvl_i;
endmodule

// File: rtl/sar_search_reg.sv
// Binary search register with a one-hot probe marking the bit under trial.
module sar_search_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         clear_i,
  input  logic         cmp_i,
  output logic [W-1:0] code_o,
  output logic [W-1:0] resolved_o,
  output logic         last_o
);
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] code_q;
  logic [W-1:0] probe_q;

  // The current bit is kept on a positive decision, cleared otherwise.
  assign resolved_o = cmp_i ? code_q : (code_q & ~probe_q);
  assign last_o     = probe_q[0];
  assign code_o     = code_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      code_q  <= '0;
      probe_q <= '0;
    end else if (load_i) begin
      code_q  <= TOP_BIT;
      probe_q <= TOP_BIT;
    end else if (step_i) begin
      code_q  <= resolved_o | (probe_q >> 1);
      probe_q <= probe_q >> 1;
    end
  end
endmodule

// File: rtl/sar_code_map.sv
// Registers the final code, converting offset binary to two's complement.
module sar_code_map #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] code_o,
  output logic         valid_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i) code_o <= {~bin_i[W-1], bin_i[W-2:0]};
    end
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
// Conversion sequencer: acquisition, switch opening, array grounding, trials.
module sar_seq_ctrl
  import sar_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         conv_n_i,
  input  logic         cmp_i,
  output logic         busy_o,
  output logic         pwr_on_o,
  output logic         sw_open_o,
  output logic         arr_gnd_o,
  output logic [W-1:0] dac_code_o,
  output logic [W-1:0] result_o,
  output logic         result_valid_o
);
  sar_state_e   state_q, state_d;
  logic         conv_fall;
  logic         start;
  logic         load_sr, step_sr, finish;
  logic         last_trial;
  logic [W-1:0] resolved;

  sar_fall_det u_fall (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (conv_n_i),
    .fall_o (conv_fall)
  );

  // Requests are accepted only in acquisition, so edges while busy are dropped.
  assign start   = conv_fall && (state_q == ST_ACQ);
  assign load_sr = (state_q == ST_GND);
  assign step_sr = (state_q == ST_TRIAL) && !last_trial;
  assign finish  = (state_q == ST_TRIAL) && last_trial;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACQ:   if (start) state_d = ST_OPEN;
      ST_OPEN:  state_d = ST_GND;
      ST_GND:   state_d = ST_TRIAL;
      ST_TRIAL: if (last_trial) state_d = ST_ACQ;
      default:  state_d = ST_ACQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_ACQ;
      busy_o    <= 1'b0;
      pwr_on_o  <= 1'b0;
      sw_open_o <= 1'b0;
      arr_gnd_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      busy_o    <= (state_d != ST_ACQ);
      pwr_on_o  <= (state_d != ST_ACQ);
      sw_open_o <= (state_d != ST_ACQ);
      arr_gnd_o <= (state_d == ST_GND) || (state_d == ST_TRIAL);
    end
  end

  sar_search_reg #(.W(W)) u_sr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_sr),
    .step_i     (step_sr),
    .clear_i    (finish),
    .cmp_i      (cmp_i),
    .code_o     (dac_code_o),
    .resolved_o (resolved),
    .last_o     (last_trial)
  );

  sar_code_map #(.W(W)) u_map (
    .clk     (clk),
    .rst     (rst),
    .load_i  (finish),
    .bin_i   (resolved),
    .code_o  (result_o),
    .valid_o (result_valid_o)
  );
endmodule

// File: rtl/sar_seq_ctrl_chk.sv
// Protocol checker bound to the sequencer.
module sar_seq_ctrl_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         conv_n_i,
  input logic         busy_o,
  input logic         pwr_on_o,
  input logic         sw_open_o,
  input logic         arr_gnd_o,
  input logic [W-1:0] dac_code_o,
  input logic [W-1:0] result_o,
  input logic         result_valid_o
);
  localparam int CONV_CYC = W + 2;

  int busy_cnt;
  always_ff @(posedge clk) begin
    if (rst)         busy_cnt <= 0;
    else if (busy_o) busy_cnt <= busy_cnt + 1;
    else             busy_cnt <= 0;
  end

  // R2 / R9: a conversion only begins after a low level on the request
  a_r2_start_from_req: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> !$past(conv_n_i));

  // R3: arrays reach ground only after the switches were already open
  a_r3_switch_order: assert property (@(posedge clk) disable iff (rst)
    $rose(arr_gnd_o) |-> sw_open_o && $past(sw_open_o));

  // R4: a nonzero trial code is presented during every grounded cycle after the first
  a_r4_trial_code: assert property (@(posedge clk) disable iff (rst)
    (arr_gnd_o && $past(arr_gnd_o)) |-> (dac_code_o != '0));

  // R6: busy window length
  a_r6_busy_len: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (busy_cnt == CONV_CYC));

  // R6: valid pulse coincides with busy falling
  a_r6_valid_end: assert property (@(posedge clk) disable iff (rst)
    result_valid_o |-> (!busy_o && $past(busy_o)));

  // R7: everything returns to acquisition and power-down
  a_r7_power_down: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (!pwr_on_o && !sw_open_o && !arr_gnd_o));

  // R8: result holds between valid pulses
  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    !result_valid_o |-> $stable(result_o));

  // R10: DAC idle outside conversions
  a_r10_dac_idle: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (dac_code_o == '0));
endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(.W(W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .conv_n_i       (conv_n_i),
  .busy_o         (busy_o),
  .pwr_on_o       (pwr_on_o),
  .sw_open_o      (sw_open_o),
  .arr_gnd_o      (arr_gnd_o),
  .dac_code_o     (dac_code_o),
  .result_o       (result_o),
  .result_valid_o (result_valid_o)
);

// File: tb/sar_seq_ctrl_tb.sv
`timescale 1ns/1ps
module sar_seq_ctrl_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         conv_n = 1'b1;
  logic         cmp;
  logic         busy, pwr_on, sw_open, arr_gnd, res_valid;
  logic [W-1:0] dac_code, result;
  logic [W-1:0] vin_r = '0;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  // Behavioural comparator: keep the bit when the trial does not exceed the input.
  assign cmp = (dac_code <= vin_r);

  sar_seq_ctrl #(.W(W)) u_dut (
    .clk            (clk),
    .rst            (rst),
    .conv_n_i       (conv_n),
    .cmp_i          (cmp),
    .busy_o         (busy),
    .pwr_on_o       (pwr_on),
    .sw_open_o      (sw_open),
    .arr_gnd_o      (arr_gnd),
    .dac_code_o     (dac_code),
    .result_o       (result),
    .result_valid_o (res_valid)
  );

  function automatic int exp_trial(int v, int k);
    return ((v >> (k + 1)) << (k + 1)) | (1 << k);
  endfunction

  function automatic int exp_result(int v);
    return v ^ (1 << (W - 1));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic convert(input logic [W-1:0] vin, input bit glitch);
    int busy_n;
    bit seq_ok;
    int bad_act, bad_exp;
    vin_r = vin;
    @(negedge clk);
    conv_n = 1'b0;
    @(negedge clk);
    check(busy && pwr_on && sw_open, "R2", "start outputs", {busy, pwr_on, sw_open}, 3'b111);
    check(sw_open && !arr_gnd, "R3", "first busy cycle", {sw_open, arr_gnd}, 2'b10);
    busy_n = 1;
    @(negedge clk);
    check(sw_open && arr_gnd, "R3", "arrays grounded", {sw_open, arr_gnd}, 2'b11);
    busy_n += int'(busy);
    if (glitch) conv_n = 1'b1;
    seq_ok = 1'b1; bad_act = 0; bad_exp = 0;
    for (int k = W - 1; k >= 0; k--) begin
      @(negedge clk);
      busy_n += int'(busy);
      if (seq_ok && (int'(dac_code) != exp_trial(int'(vin), k))) begin
        seq_ok = 1'b0; bad_act = int'(dac_code); bad_exp = exp_trial(int'(vin), k);
      end
      if (glitch && k == 12) conv_n = 1'b0;  // edge during busy (R9)
    end
    check(seq_ok, "R4/R5", "trial sequence", bad_act, bad_exp);
    @(negedge clk);
    check(busy_n == W + 2, "R6", "busy length", busy_n, W + 2);
    check(!busy && res_valid, "R6", "end busy/valid", {busy, res_valid}, 2'b01);
    check(int'(result) == exp_result(int'(vin)), "R8", "result", result, exp_result(int'(vin)));
    check(!pwr_on && !sw_open && !arr_gnd, "R7", "power down", {pwr_on, sw_open, arr_gnd}, 0);
    check(dac_code == '0, "R10", "dac idle", dac_code, 0);
    repeat (3) @(negedge clk);
    check(!busy && !res_valid, "R9", "no restart while held low", {busy, res_valid}, 0);
    check(int'(result) == exp_result(int'(vin)), "R8", "result held", result, exp_result(int'(vin)));
    conv_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17_3C01));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !pwr_on && !sw_open && !arr_gnd && !res_valid, "R1", "reset controls",
          {busy, pwr_on, sw_open, arr_gnd, res_valid}, 0);
    check(dac_code == '0 && result == '0, "R1", "reset data", {dac_code, result}, 0);

    // Directed corners: zero, full scale, midscale, just below midscale, one LSB.
    convert(16'h0000, 1'b0);
    convert(16'hFFFF, 1'b0);
    convert(16'h8000, 1'b0);
    convert(16'h7FFF, 1'b0);
    convert(16'h0001, 1'b0);
    convert(16'hAAAA, 1'b1);  // R9: request edge during busy
    for (int i = 0; i < 24; i++) begin
      convert(W'($urandom), (i % 5) == 0);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule